// File: doc/BRIEF.md
# Ethernet MAC control register block

This block is the 32-bit control and status register file that sits in front of a descriptor-based Ethernet MAC. Software reaches it through a simple word-wide request port: the byte offset is divided by four to pick a register, and any offset whose two low bits are not zero is treated as unmapped. The block keeps an event register that software clears by writing ones, plus a mask register. From these it drives two registered interrupt lines. One carries the MAC-class events and the other carries the single timer-class event.

Besides plain storage, the block shapes each written value with a per-register field mask or forced bits. It carries out a soft reset, and clearing the global enable stops both descriptor engines and reloads their pointers from the ring-start registers. It also turns writes of the management frame register into single-cycle requests on a PHY port, and writes to the receive and transmit activation registers into one-cycle kick pulses for the DMA engines. The DMA engines report events on `evt_in`. The receive engine drops its active flag by pulsing `rx_stall` when it runs out of empty buffers.

Top module: `emac_csr`

## Requirements
- R1: After reset, the control register (word 4) reads 0xF0000000, statistics control (word 7) reads 0xC0000000, receive control (word 8) reads 0x05EE0001 and the opcode register (word 10) reads 0x00010000. Every other word reads 0, and both descriptor pointer outputs are 0.
- R2: Writing the event register (word 0) clears each bit written as 1 and keeps the rest. An `evt_in` bit that arrives in the same cycle as a write clearing it stays set.
- R3: The mask register (word 1) is plain read/write. `irq_tmr` is high exactly when bit 15 is set in both event and mask. `irq_mac` is high exactly when any other bit is set in both. Both lines change on the same clock edge as the register update that causes the change.
- R4: A write to control with bit 0 set stores nothing. Instead it returns every register, both pointers and the receive-active flag to their R1 values.
- R5: A control write (without bit 0) that leaves enable bit 1 clear stores the value, clears the receive-active flag and reloads both descriptor pointers from the ring-start registers.
- R6: A write to the management register (word 5) stores the value and, on the next cycle, raises `phy_req` for one cycle with `phy_sel` = bits 27:18. If bit 29 is set, `phy_rd` is 1 and the `phy_rdata` sampled in that cycle replaces bits 15:0. Otherwise `phy_wdata` = bits 15:0. In both cases event bit 23 is set at the end of that cycle.
- R7: Stored values are shaped as follows. The clock divider (word 6) is masked with 0xFE. Receive control is masked with 0x07FF003F. Maximum buffer size (word 13) is masked with 0x3FF0. The opcode register keeps bits 15:0 and forces bit 16. Statistics control stores 0xC0000000 if bit 31 is written as 1, and 0 otherwise.
- R8: A write to transmit control (word 9) with bit 0 set sets event bit 28 on the same edge. With bit 0 clear, the value is stored and no event is raised.
- R9: While enable is clear, writes to the receive activation register (word 2) and the transmit activation register (word 3) do nothing. While enable is set, a write to word 3 gives a one-cycle `tx_kick`. A write to word 2 while the receive engine is not yet active sets the active flag (read back as bit 24 of word 2) and gives a one-cycle `rx_kick`. `rx_stall` clears the flag. Word 3 always reads 0.
- R10: Writes to the receive ring start (word 11) and transmit ring start (word 12) clear the low three bits and load the matching descriptor pointer output.
- R11: Reads of unmapped or misaligned offsets return 0 and raise `bad_access` for one cycle. Writes to them change nothing.
- R12: A read request gives `rd_valid` and its data one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| req_valid | input | 1 | register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | byte offset of the access |
| req_wdata | input | 32 | write data |
| rd_valid | output | 1 | read data valid |
| rd_data | output | 32 | read data |
| bad_access | output | 1 | one-cycle strobe for an unmapped read |
| evt_in | input | 32 | event set pulses from the DMA and timer |
| rx_stall | input | 1 | receive engine out of buffers |
| irq_mac | output | 1 | MAC-class interrupt |
| irq_tmr | output | 1 | timer-class interrupt |
| rx_kick | output | 1 | receive descriptor activation pulse |
| tx_kick | output | 1 | transmit descriptor activation pulse |
| rx_desc_ptr | output | 32 | current receive descriptor pointer |
| tx_desc_ptr | output | 32 | current transmit descriptor pointer |
| phy_req | output | 1 | management request strobe |
| phy_rd | output | 1 | management request is a read |
| phy_sel | output | 10 | PHY and register select |
| phy_wdata | output | 16 | management write data |
| phy_rdata | input | 16 | management read data, valid while phy_req |

## Verification
Register updates, kicks, interrupt levels and the transmit-control event all appear one edge after the request edge. The bench therefore checks them at the falling edge right after the write returns. Read data and `bad_access` also come one edge after the read request and are sampled at the next falling edge. Management requests lag one edge more: `phy_req` is checked at the first falling edge, and the deposited read data and the done event are checked on a later read. Event pulses on `evt_in` are held for exactly one cycle, so each set-versus-clear case is timed to a known edge.

// File: rtl/emac_csr_pkg.sv
package emac_csr_pkg;
   // word indexes of the register file
   localparam int IX_EVT    = 0;
   localparam int IX_MASK   = 1;
   localparam int IX_RXACT  = 2;
   localparam int IX_TXACT  = 3;
   localparam int IX_CTRL   = 4;
   localparam int IX_MGMT   = 5;
   localparam int IX_MDC    = 6;
   localparam int IX_STATS  = 7;
   localparam int IX_RXCTL  = 8;
   localparam int IX_TXCTL  = 9;
   localparam int IX_OPC    = 10;
   localparam int IX_RXRING = 11;
   localparam int IX_TXRING = 12;
   localparam int IX_MAXBUF = 13;
   localparam int N_REGS    = 14;

   // reset values
   localparam logic [31:0] RST_CTRL  = 32'hF000_0000;
   localparam logic [31:0] RST_STATS = 32'hC000_0000;
   localparam logic [31:0] RST_RXCTL = 32'h05EE_0001;
   localparam logic [31:0] RST_OPC   = 32'h0001_0000;

   // write shaping
   localparam logic [31:0] MSK_MDC    = 32'h0000_00FE;
   localparam logic [31:0] MSK_RXCTL  = 32'h07FF_003F;
   localparam logic [31:0] MSK_MAXBUF = 32'h0000_3FF0;
   localparam logic [31:0] MSK_OPC    = 32'h0000_FFFF;
   localparam logic [31:0] FRC_OPC    = 32'h0001_0000;

   // field positions
   localparam int RXACT_BIT = 24;
   localparam int MG_RD_BIT = 29;
   localparam int MG_SEL_LO = 18;
   localparam int MG_SEL_W  = 10;
   localparam int MG_DAT_W  = 16;
endpackage

// File: rtl/emac_csr_decode.sv
module emac_csr_decode #(
   parameter int ADDR_W = 8,
   parameter int NREG   = 14
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [NREG-1:0]   hit,
   output logic              mapped
);
   localparam int IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0] idx;
   logic             aligned;

   assign idx     = addr[ADDR_W-1:2];
   assign aligned = (addr[1:0] == 2'b00);

   for (genvar g = 0; g < NREG; g++) begin : g_hit
      assign hit[g] = aligned && (idx == IDX_W'(g));
   end

   assign mapped = |hit;
endmodule

// File: rtl/emac_csr_irq.sv
module emac_csr_irq #(
   parameter int                       N_LINES = 2,
   parameter logic [N_LINES*32-1:0]    CLASSES = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [31:0]        evt_d,
   input  logic [31:0]        mask_d,
   output logic [N_LINES-1:0] irq
);
   for (genvar g = 0; g < N_LINES; g++) begin : g_line
      localparam logic [31:0] CLS = CLASSES[g*32 +: 32];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq[g] <= 1'b0;
         else        irq[g] <= |(evt_d & mask_d & CLS);
      end
   end
endmodule

// File: rtl/emac_csr_mgmt.sv
module emac_csr_mgmt
   import emac_csr_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                start,
   input  logic [31:0]         frame,
   output logic                phy_req,
   output logic                phy_rd,
   output logic [MG_SEL_W-1:0] phy_sel,
   output logic [MG_DAT_W-1:0] phy_wdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phy_req   <= 1'b0;
         phy_rd    <= 1'b0;
         phy_sel   <= '0;
         phy_wdata <= '0;
      end else if (clr) begin
         phy_req   <= 1'b0;
      end else begin
         phy_req <= start;
         if (start) begin
            phy_rd    <= frame[MG_RD_BIT];
            phy_sel   <= frame[MG_SEL_LO +: MG_SEL_W];
            phy_wdata <= frame[MG_DAT_W-1:0];
         end
      end
   end
endmodule

// File: rtl/emac_csr.sv
module emac_csr
   import emac_csr_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DESC_ALIGN = 3,
   parameter int TMR_EVT    = 15,
   parameter int MII_EVT    = 23,
   parameter int GRACE_EVT  = 28,
   parameter int EN_BIT     = 1,
   parameter int SRST_BIT   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   output logic              rd_valid,
   output logic [31:0]       rd_data,
   output logic              bad_access,
   input  logic [31:0]       evt_in,
   input  logic              rx_stall,
   output logic              irq_mac,
   output logic              irq_tmr,
   output logic              rx_kick,
   output logic              tx_kick,
   output logic [31:0]       rx_desc_ptr,
   output logic [31:0]       tx_desc_ptr,
   output logic              phy_req,
   output logic              phy_rd,
   output logic [9:0]        phy_sel,
   output logic [15:0]       phy_wdata,
   input  logic [15:0]       phy_rdata
);
   localparam logic [31:0] TMR_CLS   = 32'(1) << TMR_EVT;
   localparam logic [31:0] MAC_CLS   = ~TMR_CLS;
   localparam logic [31:0] RING_MASK = ~((32'(1) << DESC_ALIGN) - 32'(1));
   localparam logic [31:0] MII_SET   = 32'(1) << MII_EVT;
   localparam logic [31:0] GRACE_SET = 32'(1) << GRACE_EVT;

   if (ADDR_W < 6 || ADDR_W > 16) begin : g_chk_addr
      $error("emac_csr: ADDR_W must lie in 6..16");
   end
   if (TMR_EVT == MII_EVT || TMR_EVT == GRACE_EVT || TMR_EVT > 31) begin : g_chk_evt
      $error("emac_csr: timer event bit must be distinct and below 32");
   end
   if (EN_BIT == SRST_BIT || DESC_ALIGN < 2 || DESC_ALIGN > 8) begin : g_chk_ctl
      $error("emac_csr: bad control or alignment parameter");
   end

   logic [N_REGS-1:0] hit;
   logic              mapped, wr, rd, srst, mg_start;

   emac_csr_decode #(.ADDR_W(ADDR_W), .NREG(N_REGS)) u_dec (
      .addr(req_addr), .hit(hit), .mapped(mapped));

   assign wr       = req_valid && req_write;
   assign rd       = req_valid && !req_write;
   assign srst     = wr && hit[IX_CTRL] && req_wdata[SRST_BIT];
   assign mg_start = wr && hit[IX_MGMT];

   logic [31:0] evt_q, mask_q, ctrl_q, mgmt_q, mdc_q, stats_q, rxctl_q, txctl_q;
   logic [31:0] opc_q, rxring_q, txring_q, maxbuf_q, rx_ptr_q, tx_ptr_q;
   logic [31:0] evt_d, mask_d, ctrl_d, mgmt_d, mdc_d, stats_d, rxctl_d, txctl_d;
   logic [31:0] opc_d, rxring_d, txring_d, maxbuf_d, rx_ptr_d, tx_ptr_d;
   logic        rx_act_q, rx_act_d, rx_kick_d, tx_kick_d, grace_set;

   always_comb begin
      evt_d = evt_q;   mask_d = mask_q;   ctrl_d = ctrl_q;     mgmt_d = mgmt_q;
      mdc_d = mdc_q;   stats_d = stats_q; rxctl_d = rxctl_q;   txctl_d = txctl_q;
      opc_d = opc_q;   rxring_d = rxring_q; txring_d = txring_q; maxbuf_d = maxbuf_q;
      rx_ptr_d = rx_ptr_q; tx_ptr_d = tx_ptr_q; rx_act_d = rx_act_q;
      rx_kick_d = 1'b0; tx_kick_d = 1'b0; grace_set = 1'b0;

      if (rx_stall) rx_act_d = 1'b0;
      if (phy_req && phy_rd) mgmt_d[MG_DAT_W-1:0] = phy_rdata;

      if (wr) begin
         if (hit[IX_EVT])  evt_d  = evt_q & ~req_wdata;
         if (hit[IX_MASK]) mask_d = req_wdata;
         if (hit[IX_RXACT] && ctrl_q[EN_BIT] && !rx_act_q) begin
            rx_act_d  = 1'b1;
            rx_kick_d = 1'b1;
         end
         if (hit[IX_TXACT] && ctrl_q[EN_BIT]) tx_kick_d = 1'b1;
         if (hit[IX_CTRL]) begin
            ctrl_d = req_wdata;
            if (!req_wdata[EN_BIT]) begin
               rx_act_d = 1'b0;
               rx_ptr_d = rxring_q;
               tx_ptr_d = txring_q;
            end
         end
         if (hit[IX_MGMT])  mgmt_d  = req_wdata;
         if (hit[IX_MDC])   mdc_d   = req_wdata & MSK_MDC;
         if (hit[IX_STATS]) stats_d = req_wdata[31] ? RST_STATS : 32'h0;
         if (hit[IX_RXCTL]) rxctl_d = req_wdata & MSK_RXCTL;
         if (hit[IX_TXCTL]) begin
            txctl_d   = req_wdata;
            grace_set = req_wdata[0];
         end
         if (hit[IX_OPC]) opc_d = (req_wdata & MSK_OPC) | FRC_OPC;
         if (hit[IX_RXRING]) begin
            rxring_d = req_wdata & RING_MASK;
            rx_ptr_d = req_wdata & RING_MASK;
         end
         if (hit[IX_TXRING]) begin
            txring_d = req_wdata & RING_MASK;
            tx_ptr_d = req_wdata & RING_MASK;
         end
         if (hit[IX_MAXBUF]) maxbuf_d = req_wdata & MSK_MAXBUF;
      end

      evt_d = evt_d | evt_in | (phy_req ? MII_SET : 32'h0) | (grace_set ? GRACE_SET : 32'h0);

      if (srst) begin
         evt_d = '0;  mask_d = '0;  ctrl_d = RST_CTRL; mgmt_d = '0; mdc_d = '0;
         stats_d = RST_STATS; rxctl_d = RST_RXCTL; txctl_d = '0; opc_d = RST_OPC;
         rxring_d = '0; txring_d = '0; maxbuf_d = '0; rx_ptr_d = '0; tx_ptr_d = '0;
         rx_act_d = 1'b0; rx_kick_d = 1'b0; tx_kick_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_q <= '0;  mask_q <= '0;  ctrl_q <= RST_CTRL; mgmt_q <= '0; mdc_q <= '0;
         stats_q <= RST_STATS; rxctl_q <= RST_RXCTL; txctl_q <= '0; opc_q <= RST_OPC;
         rxring_q <= '0; txring_q <= '0; maxbuf_q <= '0; rx_ptr_q <= '0; tx_ptr_q <= '0;
         rx_act_q <= 1'b0; rx_kick <= 1'b0; tx_kick <= 1'b0;
      end else begin
         evt_q <= evt_d;  mask_q <= mask_d;  ctrl_q <= ctrl_d;  mgmt_q <= mgmt_d;
         mdc_q <= mdc_d;  stats_q <= stats_d; rxctl_q <= rxctl_d; txctl_q <= txctl_d;
         opc_q <= opc_d;  rxring_q <= rxring_d; txring_q <= txring_d; maxbuf_q <= maxbuf_d;
         rx_ptr_q <= rx_ptr_d; tx_ptr_q <= tx_ptr_d; rx_act_q <= rx_act_d;
         rx_kick <= rx_kick_d; tx_kick <= tx_kick_d;
      end
   end

   assign rx_desc_ptr = rx_ptr_q;
   assign tx_desc_ptr = tx_ptr_q;

   // interrupt lines, registered from next-state values
   logic [1:0] irq_v;
   emac_csr_irq #(.N_LINES(2), .CLASSES({TMR_CLS, MAC_CLS})) u_irq (
      .clk(clk), .rst_n(rst_n), .evt_d(evt_d), .mask_d(mask_d), .irq(irq_v));
   assign irq_mac = irq_v[0];
   assign irq_tmr = irq_v[1];

   emac_csr_mgmt u_mgmt (
      .clk(clk), .rst_n(rst_n), .clr(srst), .start(mg_start), .frame(req_wdata),
      .phy_req(phy_req), .phy_rd(phy_rd), .phy_sel(phy_sel), .phy_wdata(phy_wdata));

   // read path: hit-vector AND-OR mux
   logic [N_REGS-1:0][31:0] rd_vec;
   logic [31:0]             rd_mux;
   assign rd_vec[IX_EVT]    = evt_q;
   assign rd_vec[IX_MASK]   = mask_q;
   assign rd_vec[IX_RXACT]  = 32'(rx_act_q) << RXACT_BIT;
   assign rd_vec[IX_TXACT]  = 32'h0;
   assign rd_vec[IX_CTRL]   = ctrl_q;
   assign rd_vec[IX_MGMT]   = mgmt_q;
   assign rd_vec[IX_MDC]    = mdc_q;
   assign rd_vec[IX_STATS]  = stats_q;
   assign rd_vec[IX_RXCTL]  = rxctl_q;
   assign rd_vec[IX_TXCTL]  = txctl_q;
   assign rd_vec[IX_OPC]    = opc_q;
   assign rd_vec[IX_RXRING] = rxring_q;
   assign rd_vec[IX_TXRING] = txring_q;
   assign rd_vec[IX_MAXBUF] = maxbuf_q;

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < N_REGS; i++) rd_mux = rd_mux | (rd_vec[i] & {32{hit[i]}});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid   <= 1'b0;
         rd_data    <= '0;
         bad_access <= 1'b0;
      end else begin
         rd_valid   <= rd;
         bad_access <= rd && !mapped;
         if (rd) rd_data <= rd_mux;
      end
   end
endmodule

// File: rtl/emac_csr_chk.sv
module emac_csr_chk #(
   parameter int ADDR_W    = 8,
   parameter int TMR_EVT   = 15,
   parameter int MII_EVT   = 23,
   parameter int EN_BIT    = 1,
   parameter int SRST_BIT  = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic [31:0]       req_wdata,
   input logic [31:0]       evt_in,
   input logic [31:0]       evt_q,
   input logic [31:0]       mask_q,
   input logic [31:0]       ctrl_q,
   input logic              rx_act_q,
   input logic [31:0]       rx_ptr_q,
   input logic [31:0]       rxring_q,
   input logic              irq_mac,
   input logic              irq_tmr,
   input logic              rx_kick,
   input logic              tx_kick,
   input logic              bad_access,
   input logic              rd_valid,
   input logic              phy_req
);
   localparam logic [31:0] TMR_CLS = 32'(1) << TMR_EVT;
   localparam int          IDX_W   = ADDR_W - 2;

   logic wr_any, wr_evt, wr_ctl;
   assign wr_any = req_valid && req_write;
   assign wr_evt = wr_any && req_addr[1:0] == 2'b00 && req_addr[ADDR_W-1:2] == IDX_W'(0);
   assign wr_ctl = wr_any && req_addr[1:0] == 2'b00 && req_addr[ADDR_W-1:2] == IDX_W'(4);

   p_irq_mac_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_mac == |(evt_q & mask_q & ~TMR_CLS));
   p_irq_tmr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_tmr == |(evt_q & mask_q & TMR_CLS));
   p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_evt && evt_in == 32'h0 && !phy_req) |=> evt_q == ($past(evt_q) & ~$past(req_wdata)));
   p_srst_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && req_wdata[SRST_BIT]) |=> (ctrl_q == 32'hF000_0000 && evt_q == 32'h0 && mask_q == 32'h0));
   p_dis_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && !req_wdata[SRST_BIT] && !req_wdata[EN_BIT]) |=> (!rx_act_q && rx_ptr_q == $past(rxring_q)));
   p_mii_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (phy_req && !wr_any) |=> evt_q[MII_EVT]);
   p_rx_kick_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_kick |-> ($past(ctrl_q[EN_BIT]) && rx_act_q));
   p_tx_kick_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_kick |-> $past(ctrl_q[EN_BIT]));
   p_bad_rd_r11: assert property (@(posedge clk) disable iff (!rst_n)
      bad_access |-> $past(req_valid && !req_write));
   p_rd_lat_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rd_valid);
endmodule

bind emac_csr emac_csr_chk #(
   .ADDR_W(ADDR_W), .TMR_EVT(TMR_EVT), .MII_EVT(MII_EVT), .EN_BIT(EN_BIT), .SRST_BIT(SRST_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_addr(req_addr), .req_wdata(req_wdata), .evt_in(evt_in), .evt_q(evt_q),
   .mask_q(mask_q), .ctrl_q(ctrl_q), .rx_act_q(rx_act_q), .rx_ptr_q(rx_ptr_q),
   .rxring_q(rxring_q), .irq_mac(irq_mac), .irq_tmr(irq_tmr), .rx_kick(rx_kick),
   .tx_kick(tx_kick), .bad_access(bad_access), .rd_valid(rd_valid), .phy_req(phy_req)
);

// File: tb/emac_csr_tb.sv
`timescale 1ns/1ps
module emac_csr_tb;
   localparam int AW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [31:0] req_wdata = '0, evt_in = '0;
   logic rx_stall = 1'b0;
   logic rd_valid, bad_access, irq_mac, irq_tmr, rx_kick, tx_kick, phy_req, phy_rd;
   logic [31:0] rd_data, rx_desc_ptr, tx_desc_ptr;
   logic [9:0] phy_sel;
   logic [15:0] phy_wdata, phy_rdata;

   int n_chk = 0, n_bad = 0;

   always #10 clk = ~clk;

   assign phy_rdata = {6'h2A, phy_sel};   // PHY model: answers in the request cycle

   emac_csr u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
      .bad_access(bad_access), .evt_in(evt_in), .rx_stall(rx_stall), .irq_mac(irq_mac),
      .irq_tmr(irq_tmr), .rx_kick(rx_kick), .tx_kick(tx_kick), .rx_desc_ptr(rx_desc_ptr),
      .tx_desc_ptr(tx_desc_ptr), .phy_req(phy_req), .phy_rd(phy_rd), .phy_sel(phy_sel),
      .phy_wdata(phy_wdata), .phy_rdata(phy_rdata));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] rst_val(int ix);
      case (ix)
         4:  return 32'hF000_0000;
         7:  return 32'hC000_0000;
         8:  return 32'h05EE_0001;
         10: return 32'h0001_0000;
         default: return 32'h0;
      endcase
   endfunction

   task automatic wr(int ix, logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(ix * 4); req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic rd_raw(logic [AW-1:0] a, output logic [31:0] d, output logic bad);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R12 rd_valid", 32'(rd_valid), 32'h1);
      d = rd_data; bad = bad_access;
   endtask

   task automatic rd_chk(string req, int ix, logic [31:0] exp);
      logic [31:0] d; logic b;
      rd_raw(AW'(ix * 4), d, b);
      chk(req, d, exp);
   endtask

   task automatic pulse_evt(logic [31:0] e);
      @(negedge clk); evt_in = e;
      @(negedge clk); evt_in = '0;
   endtask

   initial begin
      logic [31:0] d, fr, pats [4];
      logic b;
      pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0; pats[2] = 32'hA5A5_A5A5; pats[3] = 32'h5A5A_5A5A;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 / R11: sweep of every word index after reset
      chk("R1 rx ptr", rx_desc_ptr, 32'h0);
      chk("R1 irq", {30'h0, irq_mac, irq_tmr}, 32'h0);
      for (int ix = 0; ix < 64; ix++) begin
         rd_raw(AW'(ix * 4), d, b);
         chk("R1 reset value", d, rst_val(ix));
         chk("R11 bad strobe", 32'(b), (ix > 13) ? 32'h1 : 32'h0);
      end

      // R7 / R10 / R3 mask: shaping of written values
      foreach (pats[k]) begin
         wr(6, pats[k]);  rd_chk("R7 mdc", 6, pats[k] & 32'hFE);
         wr(8, pats[k]);  rd_chk("R7 rxctl", 8, pats[k] & 32'h07FF_003F);
         wr(13, pats[k]); rd_chk("R7 maxbuf", 13, pats[k] & 32'h3FF0);
         wr(10, pats[k]); rd_chk("R7 opcode", 10, (pats[k] & 32'hFFFF) | 32'h1_0000);
         wr(7, pats[k]);  rd_chk("R7 stats", 7, pats[k][31] ? 32'hC000_0000 : 32'h0);
         wr(1, pats[k]);  rd_chk("R3 mask rw", 1, pats[k]);
         wr(11, pats[k]); chk("R10 rx ptr", rx_desc_ptr, pats[k] & ~32'h7);
         rd_chk("R10 rx ring", 11, pats[k] & ~32'h7);
         wr(12, pats[k]); chk("R10 tx ptr", tx_desc_ptr, pats[k] & ~32'h7);
      end

      // R2: write-one-to-clear and set-over-clear
      wr(1, 32'h0);
      wr(0, 32'hFFFF_FFFF); rd_chk("R2 clear all", 0, 32'h0);
      pulse_evt(32'h0000_8011); rd_chk("R2 set", 0, 32'h0000_8011);
      wr(0, 32'h0000_0011); rd_chk("R2 partial clear", 0, 32'h0000_8000);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(0); req_wdata = 32'h8000; evt_in = 32'h8000;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; evt_in = '0;
      rd_chk("R2 set wins", 0, 32'h0000_8000);

      // R3: interrupt lines by class
      pulse_evt(32'h0000_0001);
      chk("R3 masked off", {30'h0, irq_mac, irq_tmr}, 32'h0);
      wr(1, 32'h1);       chk("R3 mac line", {30'h0, irq_mac, irq_tmr}, 32'h2);
      wr(1, 32'h8000);    chk("R3 tmr line", {30'h0, irq_mac, irq_tmr}, 32'h1);
      wr(0, 32'h8000);    chk("R3 tmr clear", {30'h0, irq_mac, irq_tmr}, 32'h0);
      pulse_evt(32'h8000); chk("R3 tmr event", 32'(irq_tmr), 32'h1);
      wr(1, 32'h0); wr(0, 32'hFFFF_FFFF);

      // R9: activation while disabled, then enabled
      wr(2, 32'h0); chk("R9 no rx kick disabled", 32'(rx_kick), 32'h0);
      rd_chk("R9 rx inactive", 2, 32'h0);
      wr(3, 32'h0); chk("R9 no tx kick disabled", 32'(tx_kick), 32'h0);
      wr(4, 32'hF000_0002);
      wr(11, 32'h1234_567F);
      wr(2, 32'h0); chk("R9 rx kick", 32'(rx_kick), 32'h1);
      @(negedge clk); chk("R9 rx kick one cycle", 32'(rx_kick), 32'h0);
      rd_chk("R9 rx active", 2, 32'h0100_0000);
      wr(2, 32'h0); chk("R9 no rekick", 32'(rx_kick), 32'h0);
      wr(3, 32'h0); chk("R9 tx kick", 32'(tx_kick), 32'h1);
      rd_chk("R9 tx reads 0", 3, 32'h0);
      @(negedge clk); rx_stall = 1'b1; @(negedge clk); rx_stall = 1'b0;
      rd_chk("R9 stall clears", 2, 32'h0);

      // R5: clearing enable
      wr(2, 32'h0);
      wr(4, 32'hF000_0000);
      rd_chk("R5 rx active cleared", 2, 32'h0);
      chk("R5 rx ptr reload", rx_desc_ptr, 32'h1234_5678);
      rd_chk("R5 ctrl stored", 4, 32'hF000_0000);

      // R6: management read and write
      fr = (32'h1 << 29) | (32'h155 << 18) | 32'h1234;
      wr(5, fr);
      chk("R6 phy_req", 32'(phy_req), 32'h1);
      chk("R6 phy_rd", 32'(phy_rd), 32'h1);
      chk("R6 phy_sel", 32'(phy_sel), 32'h155);
      @(negedge clk); chk("R6 req one cycle", 32'(phy_req), 32'h0);
      rd_chk("R6 read data", 5, (fr & 32'hFFFF_0000) | {16'h0, 6'h2A, 10'h155});
      rd_chk("R6 done event", 0, 32'h0080_0000);
      wr(0, 32'hFFFF_FFFF);
      fr = (32'h0AB << 18) | 32'hBEEF;
      wr(5, fr);
      chk("R6 write phy_rd", 32'(phy_rd), 32'h0);
      chk("R6 write data", 32'(phy_wdata), 32'hBEEF);
      rd_chk("R6 frame kept", 5, fr);
      rd_chk("R6 write done", 0, 32'h0080_0000);
      wr(0, 32'hFFFF_FFFF);

      // R8: graceful stop event
      wr(9, 32'h1); rd_chk("R8 event", 0, 32'h1000_0000);
      wr(0, 32'hFFFF_FFFF);
      wr(9, 32'h2); rd_chk("R8 no event", 0, 32'h0);
      rd_chk("R8 stored", 9, 32'h2);

      // R11: unmapped write, misaligned read
      wr(20, 32'hFFFF_FFFF);
      rd_raw(AW'(80), d, b);
      chk("R11 unmapped read", d, 32'h0); chk("R11 bad", 32'(b), 32'h1);
      rd_raw(AW'(6), d, b);
      chk("R11 misaligned", d, 32'h0); chk("R11 misaligned bad", 32'(b), 32'h1);
      for (int ix = 0; ix < 14; ix++) begin
         if (ix != 5 && ix != 9 && ix != 11 && ix != 12) rd_chk("R11 mapped intact", ix,
            (ix == 6) ? 32'h5A : (ix == 7) ? 32'h0 : (ix == 8) ? 32'h025A_001A :
            (ix == 10) ? 32'h0001_5A5A : (ix == 13) ? 32'h1A50 : (ix == 1) ? 32'h0 : rst_val(ix));
      end

      // R4: soft reset
      wr(1, 32'hFFFF_FFFF); pulse_evt(32'h3);
      wr(4, 32'h0000_0003);
      chk("R4 irq low", {30'h0, irq_mac, irq_tmr}, 32'h0);
      chk("R4 tx ptr", tx_desc_ptr, 32'h0);
      for (int ix = 0; ix < 14; ix++) rd_chk("R4 reset value", ix, rst_val(ix));

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule